// File: doc/BRIEF.md
# Receive Idle Time-out Counter

This block is a programmable down-counter that tells software when a two-channel serial receiver has gone quiet. Once a channel has time-out mode switched on through its command port, each character that channel places in its receive FIFO rearms the counter. The counter then waits one counter tick, loads the 16-bit preload value, and counts down once per tick. If the count reaches zero before the next character arrives, a ready flag is raised. The flag also drives an interrupt request when the mask input allows it. Software sets the preload to a little more than one character time. It is then told promptly when a message ends and bytes remain in the FIFO below its fill threshold, or when the line has stayed idle for longer than the programmed time.

While no channel is in time-out mode, the same counter works as an ordinary software timer. A start command loads the preload value and counts down, raising the ready flag and reloading each time it reaches zero. A stop command halts it and clears the flag. When both channels are in time-out mode, a character on either channel restarts the count. The time-out therefore fires only once both lines have been quiet for the whole period.

Top module: `idle_timeout_ctr`

## Requirements
- R1: After reset, time-out mode is off on both channels, the counter is stopped, and ready_flag and irq are 0. Ticks and character strobes alone do not set ready_flag.
- R2: A command write of code 0xA switches time-out mode on for the writing channel only, and code 0xC switches it off for that channel only. The command code occupies bits [4*c+3:4*c] of cmd_code for channel c.
- R3: In time-out mode, a character strobe on an enabled channel stops the counter. The first tick that follows loads the preload value N. ready_flag rises after tick N+1 counted from the strobe (N >= 1), and the counter then stays stopped.
- R4: irq is 1 exactly when ready_flag is 1 and irq_mask is 1.
- R5: A character strobe on an enabled channel clears ready_flag and irq.
- R6: Command 0xA clears ready_flag and leaves the counter stopped until the next character strobe on an enabled channel.
- R7: While any channel is in time-out mode, the start-counter command (0x8) and the stop-counter command (0x9) have no effect.
- R8: A character strobe on a channel whose time-out mode is off has no effect on the counter. With both channels enabled, a strobe on either channel restarts the count.
- R9: The preload value is {preload_hi, preload_lo}, with the upper byte as the high half.
- R10: With time-out mode off on both channels, command 0x8 loads the preload value and starts the count, one decrement per tick. On reaching zero the counter sets ready_flag, reloads and keeps running. Command 0x9 stops it and clears ready_flag.
- R11: Switching time-out mode off on the last enabled channel stops the counter and leaves ready_flag unchanged.
- R12: A character strobe in the same cycle as the tick that would end the count takes priority: the counter rearms and ready_flag is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ct_tick | input | 1 | Counter clock enable, one count step per cycle it is high |
| cmd_wr | input | 2 | Per-channel command write strobe |
| cmd_code | input | 8 | Per-channel 4-bit command codes, channel c in bits [4c+3:4c] |
| char_stb | input | 2 | Per-channel pulse: a character entered that channel's receive FIFO |
| preload_hi | input | 8 | Upper byte of the preload value |
| preload_lo | input | 8 | Lower byte of the preload value |
| irq_mask | input | 1 | Interrupt enable for the ready flag |
| ready_flag | output | 1 | Counter-ready status |
| irq | output | 1 | Interrupt request |

## Verification
The checker enforces several rules on every cycle. irq never rises without both ready_flag and the mask, and ready_flag rises only after a tick. The enable command and a qualifying character always clear the flag, and a stop command or a mode switch-off in time-out mode leaves the flag untouched. The exact tick counts need the bench's scenarios: the extra reload tick, the N+1 timing, a 16-bit preload that uses the high byte, and the two-channel idle condition. The same holds for the periodic reload in normal mode and for the priority of a character over the terminal tick.

// File: rtl/idle_to_pkg.sv
package idle_to_pkg;

   typedef enum logic [1:0] {
      CT_IDLE = 2'd0,
      CT_ARM  = 2'd1,
      CT_RUN  = 2'd2
   } ct_state_e;

   localparam logic [3:0] CODE_TO_ON   = 4'hA;
   localparam logic [3:0] CODE_TO_OFF  = 4'hC;
   localparam logic [3:0] CODE_CT_GO   = 4'h8;
   localparam logic [3:0] CODE_CT_HALT = 4'h9;

endpackage

// File: rtl/idle_to_cmd_dec.sv
module idle_to_cmd_dec #(
   parameter int CMD_W = 4
) (
   input  logic             wr,
   input  logic [CMD_W-1:0] code,
   output logic             to_on,
   output logic             to_off,
   output logic             ct_go,
   output logic             ct_halt
);
   import idle_to_pkg::*;

   localparam logic [CMD_W-1:0] K_ON   = CMD_W'(CODE_TO_ON);
   localparam logic [CMD_W-1:0] K_OFF  = CMD_W'(CODE_TO_OFF);
   localparam logic [CMD_W-1:0] K_GO   = CMD_W'(CODE_CT_GO);
   localparam logic [CMD_W-1:0] K_HALT = CMD_W'(CODE_CT_HALT);

   always_comb begin
      to_on   = wr && (code == K_ON);
      to_off  = wr && (code == K_OFF);
      ct_go   = wr && (code == K_GO);
      ct_halt = wr && (code == K_HALT);
   end

endmodule

// File: rtl/idle_to_mode_reg.sv
module idle_to_mode_reg #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] on_req,
   input  logic [NUM_CH-1:0] off_req,
   input  logic [NUM_CH-1:0] char_stb,
   output logic [NUM_CH-1:0] to_en,
   output logic              mode_on,
   output logic              char_hit,
   output logic              mode_drop
);
   logic [NUM_CH-1:0] en_q;
   logic [NUM_CH-1:0] en_d;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_comb begin
         if (on_req[c])
            en_d[c] = 1'b1;
         else if (off_req[c])
            en_d[c] = 1'b0;
         else
            en_d[c] = en_q[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= '0;
      else
         en_q <= en_d;
   end

   always_comb begin
      to_en     = en_q;
      mode_on   = |en_q;
      char_hit  = |(char_stb & en_q);
      mode_drop = (|en_q) && !(|en_d);
   end

endmodule

// File: rtl/idle_to_counter.sv
module idle_to_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             mode_on,
   input  logic             arm_req,
   input  logic             mode_drop,
   input  logic             char_hit,
   input  logic             go_req,
   input  logic             halt_req,
   input  logic [CNT_W-1:0] load_val,
   output logic             ready
);
   import idle_to_pkg::*;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   ct_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             rdy_q, rdy_d;
   logic             last_step;

   assign last_step = (cnt_q <= ONE);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      rdy_d   = rdy_q;
      if (arm_req) begin
         rdy_d   = 1'b0;
         state_d = CT_IDLE;
      end else if (mode_drop) begin
         state_d = CT_IDLE;
      end else if (mode_on) begin
         if (char_hit) begin
            rdy_d   = 1'b0;
            state_d = CT_ARM;
         end else if (tick) begin
            case (state_q)
               CT_ARM: begin
                  cnt_d   = load_val;
                  state_d = CT_RUN;
               end
               CT_RUN: begin
                  if (last_step) begin
                     cnt_d   = '0;
                     rdy_d   = 1'b1;
                     state_d = CT_IDLE;
                  end else begin
                     cnt_d = cnt_q - ONE;
                  end
               end
               default: ;
            endcase
         end
      end else begin
         if (halt_req) begin
            rdy_d   = 1'b0;
            state_d = CT_IDLE;
         end else if (go_req) begin
            cnt_d   = load_val;
            state_d = CT_RUN;
         end else if (tick && state_q == CT_RUN) begin
            if (last_step) begin
               rdy_d = 1'b1;
               cnt_d = load_val;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CT_IDLE;
         cnt_q   <= '0;
         rdy_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         rdy_q   <= rdy_d;
      end
   end

   assign ready = rdy_q;

endmodule

// File: rtl/idle_to_irq.sv
module idle_to_irq #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ready,
   input  logic mask,
   output logic irq
);
   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= ready && mask;
      end
      assign irq = irq_q && ready && mask;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = ready && mask;
   end

endmodule

// File: rtl/idle_timeout_ctr.sv
module idle_timeout_ctr #(
   parameter int NUM_CH  = 2,
   parameter int CMD_W   = 4,
   parameter int BYTE_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ct_tick,
   input  logic [NUM_CH-1:0]       cmd_wr,
   input  logic [NUM_CH*CMD_W-1:0] cmd_code,
   input  logic [NUM_CH-1:0]       char_stb,
   input  logic [BYTE_W-1:0]       preload_hi,
   input  logic [BYTE_W-1:0]       preload_lo,
   input  logic                    irq_mask,
   output logic                    ready_flag,
   output logic                    irq
);
   localparam int CNT_W = 2 * BYTE_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("idle_timeout_ctr: NUM_CH must be at least 1");
   end
   if (CMD_W < 4) begin : g_bad_cmd
      $error("idle_timeout_ctr: CMD_W must hold a 4-bit code");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("idle_timeout_ctr: BYTE_W must be positive");
   end

   logic [NUM_CH-1:0] on_req, off_req, go_req, halt_req;
   logic [NUM_CH-1:0] to_en;
   logic              mode_on, char_hit, mode_drop;
   logic              on_any, off_any, go_any, halt_any;
   logic [CNT_W-1:0]  load_val;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      idle_to_cmd_dec #(.CMD_W(CMD_W)) u_dec (
         .wr      (cmd_wr[c]),
         .code    (cmd_code[c*CMD_W +: CMD_W]),
         .to_on   (on_req[c]),
         .to_off  (off_req[c]),
         .ct_go   (go_req[c]),
         .ct_halt (halt_req[c])
      );
   end

   assign on_any   = |on_req;
   assign off_any  = |off_req;
   assign go_any   = |go_req;
   assign halt_any = |halt_req;
   assign load_val = {preload_hi, preload_lo};

   idle_to_mode_reg #(.NUM_CH(NUM_CH)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .on_req    (on_req),
      .off_req   (off_req),
      .char_stb  (char_stb),
      .to_en     (to_en),
      .mode_on   (mode_on),
      .char_hit  (char_hit),
      .mode_drop (mode_drop)
   );

   idle_to_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (ct_tick),
      .mode_on   (mode_on),
      .arm_req   (on_any),
      .mode_drop (mode_drop),
      .char_hit  (char_hit),
      .go_req    (go_any),
      .halt_req  (halt_any),
      .load_val  (load_val),
      .ready     (ready_flag)
   );

   idle_to_irq #(.REG_OUT(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .ready (ready_flag),
      .mask  (irq_mask),
      .irq   (irq)
   );

endmodule

// File: rtl/idle_timeout_ctr_chk.sv
module idle_timeout_ctr_chk (
   input logic clk,
   input logic rst_n,
   input logic ct_tick,
   input logic irq_mask,
   input logic ready_flag,
   input logic irq,
   input logic mode_on,
   input logic char_hit,
   input logic on_any,
   input logic off_any,
   input logic go_any,
   input logic halt_any
);

   a_r4_irq_needs_ready_and_mask: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ready_flag && irq_mask));

   a_r3_ready_rises_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_flag) |-> $past(ct_tick));

   a_r6_enable_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      on_any |=> !ready_flag);

   a_r5_char_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_on && char_hit) |=> !ready_flag);

   a_r7_halt_ignored_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_on && (halt_any || go_any) && !on_any && !char_hit && !ct_tick) |=> $stable(ready_flag));

   a_r11_disable_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_on && off_any && !on_any && !char_hit && !ct_tick) |=> $stable(ready_flag));

endmodule

bind idle_timeout_ctr idle_timeout_ctr_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ct_tick    (ct_tick),
   .irq_mask   (irq_mask),
   .ready_flag (ready_flag),
   .irq        (irq),
   .mode_on    (mode_on),
   .char_hit   (char_hit),
   .on_any     (on_any),
   .off_any    (off_any),
   .go_any     (go_any),
   .halt_any   (halt_any)
);

// File: tb/idle_timeout_ctr_tb_top.sv
module idle_timeout_ctr_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   localparam logic [1:0] OP_CMD = 2'd0;
   localparam logic [1:0] OP_CHR = 2'd1;
   localparam logic [1:0] OP_TCK = 2'd2;
   localparam logic [1:0] OP_MSK = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic        ch;
      logic [15:0] val;
      logic        exp_rdy;
      logic        exp_irq;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 42;
   localparam vec_t VEC [NV] = '{
      '{OP_CMD, 1'b0, 16'hA, 1'b0, 1'b0, 8'd6},   // R6 enable ch0
      '{OP_CHR, 1'b0, 16'd0, 1'b0, 1'b0, 8'd3},   // R3 char arms
      '{OP_TCK, 1'b0, 16'd5, 1'b0, 1'b0, 8'd3},   // R3 reload + 4 steps
      '{OP_TCK, 1'b0, 16'd1, 1'b1, 1'b1, 8'd3},   // R3 tick N+1 fires
      '{OP_TCK, 1'b0, 16'd3, 1'b1, 1'b1, 8'd3},   // R3 stays set
      '{OP_MSK, 1'b0, 16'd0, 1'b1, 1'b0, 8'd4},   // R4 masked
      '{OP_MSK, 1'b0, 16'd1, 1'b1, 1'b1, 8'd4},   // R4 unmasked
      '{OP_CHR, 1'b0, 16'd0, 1'b0, 1'b0, 8'd5},   // R5 char clears
      '{OP_TCK, 1'b0, 16'd6, 1'b1, 1'b1, 8'd5},   // R5 times out again
      '{OP_CMD, 1'b0, 16'hA, 1'b0, 1'b0, 8'd6},   // R6 enable clears
      '{OP_TCK, 1'b0, 16'd20, 1'b0, 1'b0, 8'd6},  // R6 held stopped
      '{OP_CMD, 1'b0, 16'h8, 1'b0, 1'b0, 8'd7},   // R7 start ignored
      '{OP_TCK, 1'b0, 16'd20, 1'b0, 1'b0, 8'd7},  // R7 still stopped
      '{OP_CHR, 1'b1, 16'd0, 1'b0, 1'b0, 8'd8},   // R8 ch1 not enabled
      '{OP_TCK, 1'b0, 16'd20, 1'b0, 1'b0, 8'd8},  // R8 no effect
      '{OP_CHR, 1'b0, 16'd0, 1'b0, 1'b0, 8'd7},   // R7 arm
      '{OP_TCK, 1'b0, 16'd3, 1'b0, 1'b0, 8'd7},   // R7 reload, 5->3
      '{OP_CMD, 1'b0, 16'h9, 1'b0, 1'b0, 8'd7},   // R7 stop ignored
      '{OP_TCK, 1'b0, 16'd3, 1'b1, 1'b1, 8'd7},   // R7 count went on
      '{OP_CMD, 1'b0, 16'h9, 1'b1, 1'b1, 8'd7},   // R7 stop does not clear
      '{OP_CMD, 1'b1, 16'hA, 1'b0, 1'b0, 8'd2},   // R2 enable ch1
      '{OP_CHR, 1'b0, 16'd0, 1'b0, 1'b0, 8'd8},   // R8 ch0 arms
      '{OP_TCK, 1'b0, 16'd4, 1'b0, 1'b0, 8'd8},   // R8 partway
      '{OP_CHR, 1'b1, 16'd0, 1'b0, 1'b0, 8'd8},   // R8 ch1 restarts
      '{OP_TCK, 1'b0, 16'd5, 1'b0, 1'b0, 8'd8},   // R8 not yet
      '{OP_TCK, 1'b0, 16'd1, 1'b1, 1'b1, 8'd8},   // R8 both idle
      '{OP_CMD, 1'b0, 16'hC, 1'b1, 1'b1, 8'd2},   // R2 ch0 off only
      '{OP_CHR, 1'b0, 16'd0, 1'b1, 1'b1, 8'd2},   // R2 ch0 char ignored now
      '{OP_CMD, 1'b1, 16'hC, 1'b1, 1'b1, 8'd11},  // R11 last off keeps ready
      '{OP_TCK, 1'b0, 16'd10, 1'b1, 1'b1, 8'd11}, // R11 counter stopped
      '{OP_CMD, 1'b0, 16'h9, 1'b0, 1'b0, 8'd10},  // R10 stop clears
      '{OP_CMD, 1'b0, 16'h8, 1'b0, 1'b0, 8'd10},  // R10 start loads 5
      '{OP_TCK, 1'b0, 16'd4, 1'b0, 1'b0, 8'd10},  // R10 down to 1
      '{OP_TCK, 1'b0, 16'd1, 1'b1, 1'b1, 8'd10},  // R10 zero reached
      '{OP_CMD, 1'b0, 16'h9, 1'b0, 1'b0, 8'd10},  // R10 stop clears
      '{OP_CMD, 1'b1, 16'h8, 1'b0, 1'b0, 8'd10},  // R10 start via ch1
      '{OP_TCK, 1'b0, 16'd5, 1'b1, 1'b1, 8'd10},  // R10 fires
      '{OP_TCK, 1'b0, 16'd5, 1'b1, 1'b1, 8'd10},  // R10 periodic
      '{OP_CMD, 1'b1, 16'h9, 1'b0, 1'b0, 8'd10},  // R10 stop
      '{OP_TCK, 1'b0, 16'd10, 1'b0, 1'b0, 8'd10}, // R10 halted
      '{OP_CHR, 1'b1, 16'd0, 1'b0, 1'b0, 8'd1},   // R1 mode off, char inert
      '{OP_TCK, 1'b0, 16'd8, 1'b0, 1'b0, 8'd1}    // R1 stays clear
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ct_tick = 1'b0;
   logic [1:0] cmd_wr = '0;
   logic [7:0] cmd_code = '0;
   logic [1:0] char_stb = '0;
   logic [7:0] preload_hi = 8'd0;
   logic [7:0] preload_lo = 8'd5;
   logic       irq_mask = 1'b1;
   logic       ready_flag;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   idle_timeout_ctr dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ct_tick    (ct_tick),
      .cmd_wr     (cmd_wr),
      .cmd_code   (cmd_code),
      .char_stb   (char_stb),
      .preload_hi (preload_hi),
      .preload_lo (preload_lo),
      .irq_mask   (irq_mask),
      .ready_flag (ready_flag),
      .irq        (irq)
   );

   task automatic check(input string tag, input logic er, input logic ei);
      n_checks++;
      if (ready_flag !== er || irq !== ei) begin
         n_fail++;
         $display("FAIL %s: ready=%0b irq=%0b expected ready=%0b irq=%0b",
                  tag, ready_flag, irq, er, ei);
      end
   endtask

   task automatic do_cmd(input int ch, input logic [3:0] code);
      cmd_wr[ch] = 1'b1;
      cmd_code[ch*4 +: 4] = code;
      @(negedge clk);
      cmd_wr = '0;
      cmd_code = '0;
   endtask

   task automatic do_chr(input int ch);
      char_stb[ch] = 1'b1;
      @(negedge clk);
      char_stb = '0;
   endtask

   task automatic do_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         ct_tick = 1'b1;
         @(negedge clk);
         ct_tick = 1'b0;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state", 1'b0, 1'b0);
      do_chr(0);
      do_ticks(12);
      check("R1 ticks and chars inert after reset", 1'b0, 1'b0);

      for (int k = 0; k < NV; k++) begin
         case (VEC[k].op)
            OP_CMD: do_cmd(int'(VEC[k].ch), VEC[k].val[3:0]);
            OP_CHR: do_chr(int'(VEC[k].ch));
            OP_TCK: do_ticks(int'(VEC[k].val));
            default: begin
               irq_mask = VEC[k].val[0];
               @(negedge clk);
            end
         endcase
         check($sformatf("R%0d vector %0d", VEC[k].req, k), VEC[k].exp_rdy, VEC[k].exp_irq);
      end

      // R12: character in the same cycle as the terminal tick
      do_cmd(0, 4'hA);
      do_chr(0);
      do_ticks(5);
      ct_tick = 1'b1;
      char_stb[0] = 1'b1;
      @(negedge clk);
      ct_tick = 1'b0;
      char_stb = '0;
      check("R12 reload wins over terminal tick", 1'b0, 1'b0);
      do_ticks(5);
      check("R12 rearmed count not done", 1'b0, 1'b0);
      do_ticks(1);
      check("R12 rearmed count fires", 1'b1, 1'b1);

      // R9: high byte of preload used
      preload_hi = 8'd1;
      preload_lo = 8'd0;
      do_chr(0);
      check("R9 char clears before long count", 1'b0, 1'b0);
      do_ticks(256);
      check("R9 256-count not yet expired", 1'b0, 1'b0);
      do_ticks(1);
      check("R9 256-count expired", 1'b1, 1'b1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule